// File: doc/BRIEF.md
# Audio Serial Clock Generator

The block derives the three clocks of a digital audio serial link from one fast reference clock: a master clock, a bit clock (64 bit periods per frame) and a frame clock whose period is one sample. A single frame counter advances by 1, 2 or 4 each reference cycle for normal, double or quad sample rate. The master, bit and frame clocks are taken from fixed bits of that counter and registered, so all three stay phase-locked and glitch-free. With the default parameters a normal-rate frame spans 1024 reference cycles.

Whether the block drives the clocks (master) or leaves them to an external source (slave) is set by a strap pin that is captured in the first cycle after reset. A run-time write can override the strap at any time after that. The requested speed comes from two control bits, and one code of those bits is illegal. A controller FSM has three states: `ST_SLAVE` (outputs low, counter cleared), `ST_RUN` (clocks driven) and `ST_ERR` (illegal speed code, outputs low).

Its transitions are:
- SLAVE→RUN when master is requested with a legal code.
- SLAVE→ERR on the illegal code.
- RUN→SLAVE, RUN→ERR and RUN→RUN (speed reload) only on the last cycle of a frame.
- ERR→RUN or ERR→SLAVE as soon as the code becomes legal.

Top module: `aud_clkgen`

## Requirements
- R1: In the first clock cycle after `rst_n` is released, `ms_strap` is captured. 1 selects master (`clk_drive` goes to 1 and the clocks run) and 0 selects slave (`clk_drive` stays 0).
- R2: A pulse on `ms_wr_en` sets master (`ms_wr_val`=1) or slave (0) and overrides the strap. When the pulse arrives in the same cycle as the strap capture, the written value wins.
- R3: With `{spd_quad,spd_dbl}` at 00, 01 and 10, the `lrclk` period is 1024, 512 and 256 reference cycles, and `lrclk` is high for exactly half of each period.
- R4: `sclk` shows 64 rising edges in every `lrclk` period at every speed.
- R5: `mclk_out` shows 256 rising edges per frame at normal and double speed, and 128 at quad speed.
- R6: `cur_speed` reports the active rate as 0 (normal), 1 (double) or 2 (quad).
- R7: The code `{spd_quad,spd_dbl}`=11 raises `spd_err` and holds all clock outputs and `clk_drive` low. This applies in master and in slave mode. Clock generation resumes once a legal code is applied.
- R8: In slave mode `mclk_out`, `sclk`, `lrclk` and `clk_drive` stay 0. With both speed bits clear, `cur_speed` reads 2 when `slv_mclk128` is 1 and 0 otherwise.
- R9: While clocks are driven, a change of speed, mode or error code takes effect only at a frame boundary. The boundary is the `lrclk` falling edge, and `cur_speed` changes in that same cycle. A code applied two cycles before the visible falling edge governs the next frame; one applied one cycle before waits a further frame.
- R10: `lrclk` changes level only in a cycle in which `sclk` falls.
- R11: While `rst_n` is low all outputs are 0. After release in master at normal speed, the first `lrclk` high level appears on the 514th falling reference edge counted from the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_strap | input | 1 | Master/slave strap, captured after reset |
| spd_quad | input | 1 | Quad-rate request bit |
| spd_dbl | input | 1 | Double-rate request bit |
| ms_wr_en | input | 1 | One-cycle write strobe for the mode override |
| ms_wr_val | input | 1 | Written mode: 1 master, 0 slave |
| slv_mclk128 | input | 1 | In slave mode, incoming master clock is 128 × Fs |
| mclk_out | output | 1 | Generated master clock |
| sclk | output | 1 | Generated bit clock |
| lrclk | output | 1 | Generated frame clock |
| clk_drive | output | 1 | 1 while the block drives the clocks |
| spd_err | output | 1 | Illegal speed code flag |
| cur_speed | output | 2 | Active rate code |

## Verification
A speed request and the frame boundary can fall in the same cycle. The bench provokes this by counting falling edges from one `lrclk` fall. It then writes a new speed exactly two cycles before the next expected fall, and again one cycle later than that. The first case must change the very next frame length. The second must leave one more frame at the old length, which shows that the boundary test and the configuration reload agree to the cycle. The same-cycle clash between the strap capture and a mode write is also driven at reset release, and the written value must win.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        SPD_NORM = 2'd0,
        SPD_DBL  = 2'd1,
        SPD_QUAD = 2'd2
    } spd_e;

    typedef enum logic [1:0] {
        ST_SLAVE = 2'd0,
        ST_RUN   = 2'd1,
        ST_ERR   = 2'd2
    } st_e;

    // counter increment per reference cycle for each rate
    function automatic logic [2:0] spd_step(spd_e s);
        case (s)
            SPD_DBL:  return 3'd2;
            SPD_QUAD: return 3'd4;
            default:  return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/aclk_msel.sv
module aclk_msel (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic wr_en,
    input  logic wr_val,
    output logic master
);
    logic seeded;
    logic ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seeded <= 1'b0;
            ms_q   <= 1'b0;
        end else begin
            seeded <= 1'b1;
            if (wr_en)
                ms_q <= wr_val;
            else if (!seeded)
                ms_q <= strap;
        end
    end

    // before the capture edge the live request decides the first transition
    always_comb master = seeded ? ms_q : (wr_en ? wr_val : strap);

    // R1: strap captured on the first cycle out of reset unless written
    a_r1_strap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seeded) && !$past(wr_en)) |-> (ms_q == $past(strap)));

    // R2: a write overrides whatever mode was held
    a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (master == $past(wr_val)));

endmodule

// File: rtl/aclk_divider.sv
module aclk_divider #(
    parameter int FRAME_CNT = 1024,
    localparam int CW = $clog2(FRAME_CNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [2:0]    step,
    output logic [CW-1:0] cnt,
    output logic          frame_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else
            cnt <= cnt + CW'(step);
    end

    // last count before the natural wrap to zero
    always_comb frame_end = run && (cnt == (CW'(FRAME_CNT) - CW'(step)));

    // R3: a frame end while running is always followed by count zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end) |-> (cnt == '0));

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aclk_pkg::*;
#(
    parameter int SCLK_PER_FRAME = 64,
    parameter int REF_PER_SCLK   = 16
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       ms_strap,
    input  logic       spd_quad,
    input  logic       spd_dbl,
    input  logic       ms_wr_en,
    input  logic       ms_wr_val,
    input  logic       slv_mclk128,
    output logic       mclk_out,
    output logic       sclk,
    output logic       lrclk,
    output logic       clk_drive,
    output logic       spd_err,
    output logic [1:0] cur_speed
);
    localparam int FRAME_CNT = SCLK_PER_FRAME * REF_PER_SCLK;
    localparam int CW        = $clog2(FRAME_CNT);
    localparam int SB        = $clog2(REF_PER_SCLK) - 1;
    localparam int MB        = SB - 2;

    st_e           st, st_n;
    spd_e          act, act_n;
    spd_e          req_spd, slave_spd;
    logic          req_err, master, run, frame_end;
    logic [CW-1:0] cnt;

    aclk_msel u_msel (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .strap  (ms_strap),
        .wr_en  (ms_wr_en),
        .wr_val (ms_wr_val),
        .master (master)
    );

    assign run = (st == ST_RUN);

    aclk_divider #(.FRAME_CNT(FRAME_CNT)) u_div (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (spd_step(act)),
        .cnt       (cnt),
        .frame_end (frame_end)
    );

    always_comb begin
        req_err   = spd_quad && spd_dbl;
        req_spd   = spd_quad ? SPD_QUAD : (spd_dbl ? SPD_DBL : SPD_NORM);
        slave_spd = req_spd;
        if (!spd_quad && !spd_dbl && slv_mclk128)
            slave_spd = SPD_QUAD;
    end

    // next-state logic
    always_comb begin
        st_n  = st;
        act_n = act;
        unique case (st)
            ST_SLAVE: begin
                if (req_err)
                    st_n = ST_ERR;
                else if (master) begin
                    st_n  = ST_RUN;
                    act_n = req_spd;
                end
            end
            ST_RUN: begin
                if (frame_end) begin
                    if (req_err)
                        st_n = ST_ERR;
                    else if (!master)
                        st_n = ST_SLAVE;
                    else
                        act_n = req_spd;
                end
            end
            ST_ERR: begin
                if (!req_err) begin
                    if (master) begin
                        st_n  = ST_RUN;
                        act_n = req_spd;
                    end else
                        st_n = ST_SLAVE;
                end
            end
            default: st_n = ST_SLAVE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_SLAVE;
            act <= SPD_NORM;
        end else begin
            st  <= st_n;
            act <= act_n;
        end
    end

    // registered outputs
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_out  <= 1'b0;
            sclk      <= 1'b0;
            lrclk     <= 1'b0;
            clk_drive <= 1'b0;
            spd_err   <= 1'b0;
            cur_speed <= SPD_NORM;
        end else begin
            clk_drive <= run;
            sclk      <= run && cnt[SB];
            lrclk     <= run && cnt[CW-1];
            mclk_out  <= run && ((act == SPD_QUAD) ? cnt[MB+1] : cnt[MB]);
            spd_err   <= (st == ST_ERR);
            if (st == ST_SLAVE)
                cur_speed <= slave_spd;
            else
                cur_speed <= act;
        end
    end

    // R10: frame clock moves only with a falling bit clock
    a_r10_lr_on_sclk_fall: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $changed(lrclk) |-> $fell(sclk));

    // R7: error state keeps every clock quiet
    a_r7_err_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
        spd_err |-> (!sclk && !lrclk && !mclk_out && !clk_drive));

    // R8: no clock activity unless driving
    a_r8_idle_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !clk_drive |-> (!sclk && !lrclk && !mclk_out));

    // R9: while driving, rate changes coincide with a frame boundary
    a_r9_speed_at_boundary: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($changed(cur_speed) && clk_drive && $past(clk_drive)) |-> $fell(lrclk));

endmodule

// File: tb/sim_aud_clkgen.sv
module sim_aud_clkgen;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_strap = 1'b1;
    logic       spd_quad = 1'b0;
    logic       spd_dbl = 1'b0;
    logic       ms_wr_en = 1'b0;
    logic       ms_wr_val = 1'b0;
    logic       slv_mclk128 = 1'b0;
    logic       mclk_out, sclk, lrclk, clk_drive, spd_err;
    logic [1:0] cur_speed;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 ref_clk = ~ref_clk;

    aud_clkgen u0 (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .ms_strap    (ms_strap),
        .spd_quad    (spd_quad),
        .spd_dbl     (spd_dbl),
        .ms_wr_en    (ms_wr_en),
        .ms_wr_val   (ms_wr_val),
        .slv_mclk128 (slv_mclk128),
        .mclk_out    (mclk_out),
        .sclk        (sclk),
        .lrclk       (lrclk),
        .clk_drive   (clk_drive),
        .spd_err     (spd_err),
        .cur_speed   (cur_speed)
    );

    // stimulus table: speed code, frame length, master clocks per frame, rate
    localparam logic [1:0] V_CODE [3] = '{2'b00, 2'b01, 2'b10};
    localparam int V_FRAME [3] = '{1024, 512, 256};
    localparam int V_MCLK  [3] = '{256, 256, 128};
    localparam int V_RATE  [3] = '{0, 1, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        logic prev = lrclk;
        for (int i = 0; i < 6000; i++) begin
            @(negedge ref_clk);
            if (prev && !lrclk) return;
            prev = lrclk;
        end
        chk(1'b0, "R3 lrclk fall timeout", 0, 1);
    endtask

    // from a fall (or any point) until the next lrclk fall
    task automatic measure(output int frame, output int s_r, output int m_r,
                           output int hi, output int bad);
        logic ps = sclk, pm = mclk_out, pl = lrclk;
        frame = 0; s_r = 0; m_r = 0; hi = 0; bad = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge ref_clk);
            frame++;
            if (!ps && sclk) s_r++;
            if (!pm && mclk_out) m_r++;
            if (lrclk) hi++;
            if ((pl != lrclk) && !(ps && !sclk)) bad++;
            if (pl && !lrclk) return;
            ps = sclk; pm = mclk_out; pl = lrclk;
        end
        chk(1'b0, "R3 measure timeout", frame, 0);
    endtask

    task automatic set_code(input logic [1:0] c);
        spd_quad = c[1];
        spd_dbl  = c[0];
    endtask

    task automatic write_mode(input logic v);
        @(negedge ref_clk);
        ms_wr_en = 1'b1; ms_wr_val = v;
        @(negedge ref_clk);
        ms_wr_en = 1'b0;
    endtask

    task automatic quiet_for(input int n, input string req);
        int act = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (sclk || lrclk || mclk_out || clk_drive) act++;
        end
        chk(act == 0, req, act, 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge ref_clk);
            cyc++;
            if (cyc > 190000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int f, s, m, h, b, n;

        // R11: quiet in reset, first lrclk high on the 514th falling edge
        repeat (5) @(negedge ref_clk);
        chk(!sclk && !lrclk && !mclk_out && !clk_drive && !spd_err && cur_speed == 0,
            "R11 reset outputs", {sclk, lrclk, mclk_out, clk_drive}, 0);
        rst_n = 1'b1;
        n = 0;
        while (!lrclk && n < 3000) begin
            @(negedge ref_clk);
            n++;
        end
        chk(n == 514, "R11 first lrclk high", n, 514);
        chk(clk_drive, "R1 strap high gives master", clk_drive, 1);

        // table walk: R3 R4 R5 R6 R10
        for (int k = 0; k < 3; k++) begin
            set_code(V_CODE[k]);
            wait_fall();
            measure(f, s, m, h, b);
            chk(f == V_FRAME[k], "R3 frame length", f, V_FRAME[k]);
            chk(h == V_FRAME[k] / 2, "R3 lrclk duty", h, V_FRAME[k] / 2);
            chk(s == 64, "R4 sclk per frame", s, 64);
            chk(m == V_MCLK[k], "R5 mclk per frame", m, V_MCLK[k]);
            chk(b == 0, "R10 lrclk aligned to sclk fall", b, 0);
            chk(cur_speed == V_RATE[k], "R6 cur_speed", cur_speed, V_RATE[k]);
        end

        // R9: mid-frame change waits for the boundary
        set_code(2'b00);
        wait_fall();
        wait_fall();
        set_code(2'b01);
        measure(f, s, m, h, b);
        chk(f == 1024, "R9 current frame keeps old length", f, 1024);
        measure(f, s, m, h, b);
        chk(f == 512, "R9 next frame uses new length", f, 512);

        // R9: same-cycle edge, request two cycles before the fall
        wait_fall();
        repeat (510) @(negedge ref_clk);
        set_code(2'b10);
        measure(f, s, m, h, b);
        chk(f == 2, "R9 remaining cycles", f, 2);
        measure(f, s, m, h, b);
        chk(f == 256, "R9 request at boundary applied", f, 256);

        // R9: request one cycle too late waits another frame
        wait_fall();
        repeat (255) @(negedge ref_clk);
        set_code(2'b00);
        measure(f, s, m, h, b);
        chk(f == 1, "R9 remaining cycle", f, 1);
        measure(f, s, m, h, b);
        chk(f == 256, "R9 late request deferred", f, 256);
        measure(f, s, m, h, b);
        chk(f == 1024, "R9 late request then applied", f, 1024);

        // R2/R9/R8: slave write takes effect at boundary
        write_mode(1'b0);
        repeat (10) @(negedge ref_clk);
        chk(clk_drive, "R9 slave write deferred", clk_drive, 1);
        wait_fall();
        @(negedge ref_clk);
        chk(!clk_drive, "R2 write selects slave", clk_drive, 0);
        quiet_for(2000, "R8 slave outputs low");
        chk(cur_speed == 0, "R8 slave normal rate", cur_speed, 0);
        slv_mclk128 = 1'b1;
        repeat (2) @(negedge ref_clk);
        chk(cur_speed == 2, "R8 slave 128x accepted as quad", cur_speed, 2);
        set_code(2'b01);
        repeat (2) @(negedge ref_clk);
        chk(cur_speed == 1, "R8 slave double", cur_speed, 1);
        slv_mclk128 = 1'b0;

        // R7: error in slave, then master request while in error
        set_code(2'b11);
        repeat (3) @(negedge ref_clk);
        chk(spd_err, "R7 error in slave", spd_err, 1);
        write_mode(1'b1);
        quiet_for(500, "R7 error holds clocks off");
        chk(spd_err, "R7 error persists", spd_err, 1);
        set_code(2'b00);
        repeat (3) @(negedge ref_clk);
        chk(clk_drive && !spd_err, "R7 recovery to master", {clk_drive, spd_err}, 2);
        wait_fall();
        measure(f, s, m, h, b);
        chk(f == 1024, "R7 clean restart frame", f, 1024);

        // R7/R9: error in master is deferred to boundary
        set_code(2'b11);
        repeat (5) @(negedge ref_clk);
        chk(!spd_err && clk_drive, "R9 error deferred", spd_err, 0);
        wait_fall();
        chk(spd_err && !clk_drive, "R7 error at boundary", {spd_err, clk_drive}, 2);
        quiet_for(1000, "R7 master error quiet");
        set_code(2'b00);

        // R11/R1: reset mid-run, strap low gives slave
        @(negedge ref_clk);
        rst_n = 1'b0;
        ms_strap = 1'b0;
        #1;
        chk(!sclk && !lrclk && !mclk_out && !clk_drive && !spd_err,
            "R11 async reset clears", {sclk, lrclk, clk_drive}, 0);
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        quiet_for(20, "R1 strap low gives slave");

        // R2: write in the capture cycle beats the strap
        @(negedge ref_clk);
        rst_n = 1'b0;
        ms_strap = 1'b1;
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        ms_wr_en = 1'b1;
        ms_wr_val = 1'b0;
        @(negedge ref_clk);
        ms_wr_en = 1'b0;
        quiet_for(20, "R2 write beats strap");
        write_mode(1'b1);
        repeat (3) @(negedge ref_clk);
        chk(clk_drive, "R2 write selects master", clk_drive, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule